// File: doc/BRIEF.md
# Four-Slot Shared SRAM Time-Slot Arbiter

This block lets four clients share a single SRAM by handing the memory to each client in turn, one clock per slot. The rotation is fixed. Slot 0 is a video read. Slot 1 is a processor read or write. Slot 2 is an audio read. Slot 3 is a blitter read or write. In each slot the owner's address, write data and direction go straight to the SRAM pins. When the owner reads, the SRAM data is captured at the end of the slot and handed back to that owner on the next cycle with a single-cycle valid strobe.

Two configuration inputs let a system give up the audio slot or the blitter slot. When audio is turned off, slot 2 carries a second video read, which doubles video bandwidth. When the blitter is turned off, slot 3 carries a second processor access. A slot whose owner is not requesting is left idle and is never handed to anyone else. The writable slots are 1 and 3, so two writes can never reach the SRAM on consecutive cycles.

Top module: `sram_slot_arbiter`

## Requirements
- R1: While reset is asserted, and for the two synchronising clocks after it is released, `cur_slot` reads 0, `sram_en` and `sram_wr` are low, and every grant and rvalid is low. Asserting reset during operation forces this state immediately.
- R2: Once running, `cur_slot` advances by one every clock in the order 0, 1, 2, 3 and wraps back to 0. The first running cycle is slot 0.
- R3: In slot 0, a video request drives `sram_en`=1 and `sram_wr`=0, puts `vid_addr` on `sram_addr`, and raises `vid_grant`.
- R4: In slot 1, a processor request drives `sram_en`=1, puts `cpu_addr` on `sram_addr`, and raises `cpu_grant`. `sram_wr` equals `cpu_we`, and on a write `sram_wdata` equals `cpu_wdata`.
- R5: In slot 2 with `cfg_audio_off`=0, an audio request issues a read of `aud_addr` and raises `aud_grant`.
- R6: In slot 3 with `cfg_blit_off`=0, a blitter request issues an access to `blt_addr` and raises `blt_grant`. `sram_wr` equals `blt_we`, and on a write `sram_wdata` equals `blt_wdata`.
- R7: With `cfg_audio_off`=1, slot 2 serves a video read of `vid_addr` when `vid_req` is high. The audio client is never granted and never receives rvalid.
- R8: With `cfg_blit_off`=1, slot 3 serves a processor access, read or write, using `cpu_addr`, `cpu_we` and `cpu_wdata`. The blitter is never granted and never receives rvalid.
- R9: If the owner of a slot is not requesting, `sram_en`, `sram_wr` and all grants stay low for that slot. A request from any other client does not claim the slot.
- R10: A read issued in a slot makes the owner's rvalid high for exactly the next cycle, with the SRAM data sampled at the end of the slot on its rdata. At most one rvalid is high at a time, and a write never produces an rvalid.
- R11: `sram_wr` is never high in two consecutive cycles, whatever the configuration or request pattern.
- R12: `sram_wr` is only ever high in slots 1 and 3. Video and audio accesses are always reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_audio_off | input | 1 | Give slot 2 to video |
| cfg_blit_off | input | 1 | Give slot 3 to the processor |
| vid_req | input | 1 | Video read request |
| vid_addr | input | ADDR_W | Video address |
| vid_grant | output | 1 | Video access is on the SRAM this cycle |
| vid_rvalid | output | 1 | Video read data valid |
| vid_rdata | output | DATA_W | Video read data |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_grant | output | 1 | Processor access is on the SRAM this cycle |
| cpu_rvalid | output | 1 | Processor read data valid |
| cpu_rdata | output | DATA_W | Processor read data |
| aud_req | input | 1 | Audio read request |
| aud_addr | input | ADDR_W | Audio address |
| aud_grant | output | 1 | Audio access is on the SRAM this cycle |
| aud_rvalid | output | 1 | Audio read data valid |
| aud_rdata | output | DATA_W | Audio read data |
| blt_req | input | 1 | Blitter request |
| blt_we | input | 1 | Blitter write (1) or read (0) |
| blt_addr | input | ADDR_W | Blitter address |
| blt_wdata | input | DATA_W | Blitter write data |
| blt_grant | output | 1 | Blitter access is on the SRAM this cycle |
| blt_rvalid | output | 1 | Blitter read data valid |
| blt_rdata | output | DATA_W | Blitter read data |
| sram_en | output | 1 | SRAM access enable |
| sram_wr | output | 1 | SRAM write strobe |
| sram_addr | output | ADDR_W | SRAM address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_rdata | input | DATA_W | SRAM read data |
| cur_slot | output | 2 | Current slot number |

## Verification
Two things can land in the same cycle. One is the read-return strobe for the previous slot. The other is a new access, which may be a write, driven to the SRAM by the current slot's owner. The bench sets this up with every client requesting at once. In some rotations the processor and blitter read while audio or video reads sit beside them. In others a write in slot 1 or slot 3 directly follows a read in slot 0 or slot 2. Each cycle is judged on two counts. The rvalid must belong only to the previous slot's reader and carry the data the bench memory held at that address. The SRAM pins must show only the current owner's address, direction and write data.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  typedef enum logic [1:0] {
    OWN_VID = 2'd0,
    OWN_CPU = 2'd1,
    OWN_AUD = 2'd2,
    OWN_BLT = 2'd3
  } owner_e;

  localparam int unsigned N_CLIENT = 4;
  localparam int unsigned SLOT_W   = 2;
endpackage

// File: rtl/slot_phase_gen.sv
module slot_phase_gen
  import slot_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic              run_n,
  output logic [SLOT_W-1:0] phase
);
  logic              sync_a_q;
  logic              sync_b_q;
  logic [SLOT_W-1:0] phase_d;
  logic [SLOT_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a_q <= 1'b0;
      sync_b_q <= 1'b0;
    end else begin
      sync_a_q <= 1'b1;
      sync_b_q <= sync_a_q;
    end
  end

  assign run_n = sync_b_q;

  always_comb begin
    phase_d = phase_q;
    if (run_n) phase_d = phase_q + SLOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/slot_owner_map.sv
module slot_owner_map
  import slot_arb_pkg::*;
(
  input  logic                run,
  input  logic [SLOT_W-1:0]   phase,
  input  logic                audio_off,
  input  logic                blit_off,
  input  logic [N_CLIENT-1:0] req_vec,
  output owner_e              owner,
  output logic                granted
);
  always_comb begin
    unique case (phase)
      2'd0:    owner = OWN_VID;
      2'd1:    owner = OWN_CPU;
      2'd2:    owner = audio_off ? OWN_VID : OWN_AUD;
      default: owner = blit_off  ? OWN_CPU : OWN_BLT;
    endcase
    granted = run & req_vec[owner];
  end
endmodule

// File: rtl/slot_port_mux.sv
module slot_port_mux
  import slot_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  owner_e              owner,
  input  logic                granted,
  input  logic [ADDR_W-1:0]   addr_arr  [N_CLIENT],
  input  logic [DATA_W-1:0]   wdata_arr [N_CLIENT],
  input  logic [N_CLIENT-1:0] we_vec,
  output logic [N_CLIENT-1:0] grant_vec,
  output logic                mem_en,
  output logic                mem_wr,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata
);
  for (genvar g = 0; g < N_CLIENT; g++) begin : g_grant
    assign grant_vec[g] = granted && (owner == owner_e'(g));
  end

  always_comb begin
    mem_en    = granted;
    mem_wr    = granted & we_vec[owner];
    mem_addr  = granted ? addr_arr[owner] : '0;
    mem_wdata = mem_wr ? wdata_arr[owner] : '0;
  end
endmodule

// File: rtl/slot_read_return.sv
module slot_read_return
  import slot_arb_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                run_n,
  input  logic                rd_issue,
  input  owner_e              owner,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [N_CLIENT-1:0] rvalid_vec,
  output logic [DATA_W-1:0]   rdata
);
  logic              rd_d, rd_q;
  owner_e            own_d, own_q;
  logic [DATA_W-1:0] data_d, data_q;

  always_comb begin
    rd_d   = rd_issue;
    own_d  = owner;
    data_d = data_q;
    if (rd_issue) data_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      rd_q   <= 1'b0;
      own_q  <= OWN_VID;
      data_q <= '0;
    end else begin
      rd_q   <= rd_d;
      own_q  <= own_d;
      data_q <= data_d;
    end
  end

  for (genvar g = 0; g < N_CLIENT; g++) begin : g_valid
    assign rvalid_vec[g] = rd_q && (own_q == owner_e'(g));
  end
  assign rdata = data_q;
endmodule

// File: rtl/sram_slot_arbiter.sv
module sram_slot_arbiter
  import slot_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_audio_off,
  input  logic              cfg_blit_off,
  input  logic              vid_req,
  input  logic [ADDR_W-1:0] vid_addr,
  output logic              vid_grant,
  output logic              vid_rvalid,
  output logic [DATA_W-1:0] vid_rdata,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_grant,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              aud_req,
  input  logic [ADDR_W-1:0] aud_addr,
  output logic              aud_grant,
  output logic              aud_rvalid,
  output logic [DATA_W-1:0] aud_rdata,
  input  logic              blt_req,
  input  logic              blt_we,
  input  logic [ADDR_W-1:0] blt_addr,
  input  logic [DATA_W-1:0] blt_wdata,
  output logic              blt_grant,
  output logic              blt_rvalid,
  output logic [DATA_W-1:0] blt_rdata,
  output logic              sram_en,
  output logic              sram_wr,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic [1:0]        cur_slot
);
  logic                run_n;
  logic [SLOT_W-1:0]   phase;
  owner_e              owner;
  logic                granted;
  logic [N_CLIENT-1:0] req_vec;
  logic [N_CLIENT-1:0] we_vec;
  logic [N_CLIENT-1:0] grant_vec;
  logic [N_CLIENT-1:0] rvalid_vec;
  logic [ADDR_W-1:0]   addr_arr  [N_CLIENT];
  logic [DATA_W-1:0]   wdata_arr [N_CLIENT];
  logic [DATA_W-1:0]   ret_data;

  assign req_vec = {blt_req, aud_req, cpu_req, vid_req};
  assign we_vec  = {blt_we, 1'b0, cpu_we, 1'b0};

  assign addr_arr[OWN_VID]  = vid_addr;
  assign addr_arr[OWN_CPU]  = cpu_addr;
  assign addr_arr[OWN_AUD]  = aud_addr;
  assign addr_arr[OWN_BLT]  = blt_addr;
  assign wdata_arr[OWN_VID] = '0;
  assign wdata_arr[OWN_CPU] = cpu_wdata;
  assign wdata_arr[OWN_AUD] = '0;
  assign wdata_arr[OWN_BLT] = blt_wdata;

  slot_phase_gen u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .run_n (run_n),
    .phase (phase)
  );

  slot_owner_map u_map (
    .run       (run_n),
    .phase     (phase),
    .audio_off (cfg_audio_off),
    .blit_off  (cfg_blit_off),
    .req_vec   (req_vec),
    .owner     (owner),
    .granted   (granted)
  );

  slot_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .owner     (owner),
    .granted   (granted),
    .addr_arr  (addr_arr),
    .wdata_arr (wdata_arr),
    .we_vec    (we_vec),
    .grant_vec (grant_vec),
    .mem_en    (sram_en),
    .mem_wr    (sram_wr),
    .mem_addr  (sram_addr),
    .mem_wdata (sram_wdata)
  );

  slot_read_return #(.DATA_W(DATA_W)) u_ret (
    .clk        (clk),
    .run_n      (run_n),
    .rd_issue   (sram_en & ~sram_wr),
    .owner      (owner),
    .mem_rdata  (sram_rdata),
    .rvalid_vec (rvalid_vec),
    .rdata      (ret_data)
  );

  assign vid_grant  = grant_vec[OWN_VID];
  assign cpu_grant  = grant_vec[OWN_CPU];
  assign aud_grant  = grant_vec[OWN_AUD];
  assign blt_grant  = grant_vec[OWN_BLT];
  assign vid_rvalid = rvalid_vec[OWN_VID];
  assign cpu_rvalid = rvalid_vec[OWN_CPU];
  assign aud_rvalid = rvalid_vec[OWN_AUD];
  assign blt_rvalid = rvalid_vec[OWN_BLT];
  assign vid_rdata  = ret_data;
  assign cpu_rdata  = ret_data;
  assign aud_rdata  = ret_data;
  assign blt_rdata  = ret_data;
  assign cur_slot   = phase;
endmodule

// File: rtl/slot_arb_checker.sv
module slot_arb_checker (
  input logic       clk,
  input logic       run_n,
  input logic [1:0] cur_slot,
  input logic       sram_en,
  input logic       sram_wr,
  input logic       cfg_audio_off,
  input logic       cfg_blit_off,
  input logic       aud_grant,
  input logic       blt_grant,
  input logic [3:0] rvalid_vec
);
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!run_n)
    $past(run_n) |-> cur_slot == $past(cur_slot) + 2'd1); // R2

  AST_WRITE_SPACING: assert property (@(posedge clk) disable iff (!run_n)
    sram_wr |=> !sram_wr); // R11

  AST_WRITE_SLOT_ODD: assert property (@(posedge clk) disable iff (!run_n)
    sram_wr |-> cur_slot[0]); // R12

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!run_n)
    !sram_en |-> !sram_wr); // R9

  AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (!run_n)
    $onehot0(rvalid_vec)); // R10

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!run_n)
    (|rvalid_vec) |-> $past(sram_en && !sram_wr)); // R10

  AST_AUDIO_SILENT: assert property (@(posedge clk) disable iff (!run_n)
    (cfg_audio_off && $past(cfg_audio_off)) |-> (!aud_grant && !rvalid_vec[2])); // R7

  AST_BLIT_SILENT: assert property (@(posedge clk) disable iff (!run_n)
    (cfg_blit_off && $past(cfg_blit_off)) |-> (!blt_grant && !rvalid_vec[3])); // R8
endmodule

bind sram_slot_arbiter slot_arb_checker u_chk (
  .clk           (clk),
  .run_n         (run_n),
  .cur_slot      (cur_slot),
  .sram_en       (sram_en),
  .sram_wr       (sram_wr),
  .cfg_audio_off (cfg_audio_off),
  .cfg_blit_off  (cfg_blit_off),
  .aud_grant     (aud_grant),
  .blt_grant     (blt_grant),
  .rvalid_vec    ({blt_rvalid, aud_rvalid, cpu_rvalid, vid_rvalid})
);

// File: tb/sram_slot_arbiter_bench.sv
module sram_slot_arbiter_bench;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam logic [AW-1:0] A_VID = 10'h011;
  localparam logic [AW-1:0] A_CPU = 10'h022;
  localparam logic [AW-1:0] A_AUD = 10'h033;
  localparam logic [AW-1:0] A_BLT = 10'h044;

  // [11] audio_off [10] blit_off [9:6] req v,c,a,b [5] cpu_we [4] blt_we
  // [3] exp en [2] exp wr [1:0] exp source client
  localparam int NV = 24;
  localparam logic [11:0] VEC [NV] = '{
    12'h3C8, 12'h3C9, 12'h3CA, 12'h3CB,
    12'h3F8, 12'h3FD, 12'h3FA, 12'h3FF,
    12'hFE8, 12'hFED, 12'hFE8, 12'hFED,
    12'hDC0, 12'hEE0, 12'hDC0, 12'hEE0,
    12'h1C0, 12'h3C9, 12'h340, 12'h04B,
    12'hBD8, 12'hBD9, 12'hBD8, 12'hBDF
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_audio_off = 1'b0, cfg_blit_off = 1'b0;
  logic vid_req = 1'b0, cpu_req = 1'b0, aud_req = 1'b0, blt_req = 1'b0;
  logic cpu_we = 1'b0, blt_we = 1'b0;
  logic [AW-1:0] vid_addr = A_VID, cpu_addr = A_CPU, aud_addr = A_AUD, blt_addr = A_BLT;
  logic [DW-1:0] cpu_wdata = '0, blt_wdata = '0;
  logic vid_grant, cpu_grant, aud_grant, blt_grant;
  logic vid_rvalid, cpu_rvalid, aud_rvalid, blt_rvalid;
  logic [DW-1:0] vid_rdata, cpu_rdata, aud_rdata, blt_rdata;
  logic sram_en, sram_wr;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_wdata, sram_rdata;
  logic [1:0] cur_slot;
  logic [DW-1:0] mem [1024];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign sram_rdata = mem[sram_addr];
  always @(posedge clk) if (sram_en && sram_wr) mem[sram_addr] <= sram_wdata;

  sram_slot_arbiter u_sram_slot_arbiter (
    .clk(clk), .rst_n(rst_n), .cfg_audio_off(cfg_audio_off), .cfg_blit_off(cfg_blit_off),
    .vid_req(vid_req), .vid_addr(vid_addr), .vid_grant(vid_grant), .vid_rvalid(vid_rvalid), .vid_rdata(vid_rdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_grant(cpu_grant), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .aud_req(aud_req), .aud_addr(aud_addr), .aud_grant(aud_grant), .aud_rvalid(aud_rvalid), .aud_rdata(aud_rdata),
    .blt_req(blt_req), .blt_we(blt_we), .blt_addr(blt_addr), .blt_wdata(blt_wdata),
    .blt_grant(blt_grant), .blt_rvalid(blt_rvalid), .blt_rdata(blt_rdata),
    .sram_en(sram_en), .sram_wr(sram_wr), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .sram_rdata(sram_rdata), .cur_slot(cur_slot)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] src_addr(input logic [1:0] s);
    case (s)
      2'd0: return A_VID;
      2'd1: return A_CPU;
      2'd2: return A_AUD;
      default: return A_BLT;
    endcase
  endfunction

  function automatic string slot_tag(input int s, input logic aoff, input logic boff, input logic en);
    if (!en) return "R9 idle slot";
    case (s)
      0: return "R3 video slot";
      1: return "R4 processor slot";
      2: return aoff ? "R7 audio slot to video" : "R5 audio slot";
      default: return boff ? "R8 blitter slot to processor" : "R6 blitter slot";
    endcase
  endfunction

  task automatic reset_checks(input string what);
    chk({"R1 slot ", what}, 32'(cur_slot), 0);
    chk({"R1 enable ", what}, 32'({sram_en, sram_wr}), 0);
    chk({"R1 grants ", what}, 32'({vid_grant, cpu_grant, aud_grant, blt_grant}), 0);
    chk({"R1 rvalid ", what}, 32'({vid_rvalid, cpu_rvalid, aud_rvalid, blt_rvalid}), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic       pend_v;
    logic [1:0] pend_src;
    logic [DW-1:0] pend_dat;
    logic       prev_wr;
    for (int i = 0; i < 1024; i++) mem[i] = DW'(i * 7 + 3);

    vid_req = 1; cpu_req = 1; aud_req = 1; blt_req = 1;
    repeat (3) @(negedge clk);
    #1 reset_checks("in reset");
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    #1 reset_checks("during sync");
    vid_req = 0; cpu_req = 0; aud_req = 0; blt_req = 0;
    @(negedge clk);

    pend_v = 0; pend_src = 0; pend_dat = 0; prev_wr = 0;
    for (int k = 0; k < NV + 1; k++) begin
      logic [3:0] rv_exp;
      rv_exp = pend_v ? (4'b0001 << pend_src) : 4'b0000;
      chk("R10 rvalid set", 32'({blt_rvalid, aud_rvalid, cpu_rvalid, vid_rvalid}), 32'(rv_exp));
      if (pend_v) chk("R10 rdata", 32'(vid_rdata), 32'(pend_dat));
      if (k == NV) break;
      begin
        logic [11:0] v;
        string tg;
        v = VEC[k];
        cfg_audio_off = v[11]; cfg_blit_off = v[10];
        vid_req = v[9]; cpu_req = v[8]; aud_req = v[7]; blt_req = v[6];
        cpu_we = v[5]; blt_we = v[4];
        cpu_wdata = DW'(8'hC0 + k); blt_wdata = DW'(8'hB0 + k);
        #1;
        tg = slot_tag(k % 4, v[11], v[10], v[3]);
        chk("R2 slot order", 32'(cur_slot), 32'(k % 4));
        chk({tg, " enable"}, 32'(sram_en), 32'(v[3]));
        chk({tg, " write"}, 32'(sram_wr), 32'(v[2]));
        chk({tg, " grant"}, 32'({blt_grant, aud_grant, cpu_grant, vid_grant}),
            v[3] ? 32'(4'b0001 << v[1:0]) : 0);
        if (v[3]) chk({tg, " address"}, 32'(sram_addr), 32'(src_addr(v[1:0])));
        if (v[2]) chk({tg, " wdata"}, 32'(sram_wdata),
                      32'(v[1:0] == 2'd1 ? cpu_wdata : blt_wdata));
        if (sram_wr) chk("R12 write in odd slot", 32'(cur_slot[0]), 1);
        chk("R11 no consecutive writes", 32'(prev_wr & sram_wr), 0);
        prev_wr = sram_wr;
        pend_v = v[3] & ~v[2];
        pend_src = v[1:0];
        pend_dat = mem[src_addr(v[1:0])];
      end
      @(negedge clk);
    end

    // R10: written data read back by processor through the normal path
    cfg_audio_off = 0; cfg_blit_off = 0;
    vid_req = 0; aud_req = 0; blt_req = 0; cpu_req = 1; cpu_we = 0;
    while (cur_slot != 2'd1) @(negedge clk);
    #1 chk("R4 readback address", 32'(sram_addr), 32'(A_CPU));
    @(negedge clk);
    chk("R10 readback valid", 32'(cpu_rvalid), 1);
    chk("R10 readback data", 32'(cpu_rdata), 32'(DW'(8'hC0 + 11)));
    @(negedge clk);
    chk("R10 single pulse", 32'(cpu_rvalid), 0);

    // R1: reset during operation takes effect at once
    vid_req = 1; aud_req = 1; blt_req = 1;
    rst_n = 1'b0;
    #1 reset_checks("mid-run");
    @(negedge clk);
    #1 reset_checks("mid-run held");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule